// File: doc/BRIEF.md
# Two-Stage Fractional Modulator Clock Divider

This block derives the bit clock for an external sigma-delta modulator from a fast core clock. It has two divider stages in cascade. The first stage takes a ratio in steps of one half, so it accepts ratios such as 7.5 as well as 10 or 15. The second stage divides the first stage's output by a whole number. The output frequency is therefore the core frequency divided by the product of the two ratios. For example, a 300 MHz core with ratios of 15 and 1 gives 20 MHz, and ratios of 15 and 2 give 10 MHz. The output is a registered signal in the core clock domain, not a gated clock.

Each stage has its own encoded divider register, and both are written through one write strobe with a select bit. A write lands in a shadow copy of the register. The shadow value moves to the working copy only when the divider is started, or when the output rises at the end of the current period. A change in ratio therefore never produces a shortened pulse.

With a half-integer first stage, the product of the ratios can be a fraction of a core cycle. In that case successive output periods alternate between the two nearest whole cycle counts, and each pair of periods adds up to the exact ratio.

Top module: `modclk_gen`

## Requirements
- R1: After reset, `mod_clk` is low and both registers hold their defaults: stage-one code 0x1C and stage-two code 0x00. With these defaults, two consecutive output periods total 30 core cycles.
- R2: A stage-one code E selects a ratio of (E+2)/2, so 0x1C selects 15 and 0x0D selects 7.5. A stage-two code R selects a ratio of R+1. Any two consecutive output periods, measured rising edge to rising edge, total exactly (E+2)*(R+1) core cycles.
- R3: Each single output period is either floor((E+2)*(R+1)/2) or ceil((E+2)*(R+1)/2) core cycles.
- R4: Stage-one codes 0 and 1 act as code 2, which selects a ratio of 2.
- R5: While `en` is low, `mod_clk` is low. It goes low in the cycle after `en` is seen low, and it stays low for as long as `en` stays low.
- R6: In the first cycle after `en` is seen high following a low period, `mod_clk` is high.
- R7: When `cfg_we` is high, `cfg_sel`=0 writes `cfg_data` to the stage-one shadow register, and `cfg_sel`=1 writes the low stage-two bits of `cfg_data` to the stage-two shadow register. The working values change only at start or at an output rising edge. The period in progress keeps its old length, and the next period uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Divider run enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 for stage one, 1 for stage two |
| cfg_data | input | P_W | Encoded divider value to write |
| mod_clk | output | 1 | Divided modulator clock, registered |

## Verification
The in-line assertions check, on every cycle, the relations that involve a single step:
- the output is forced low while the divider is disabled;
- the output rises on start;
- the working codes stay unchanged except at a load point;
- the stage-one accumulator and the stage-two counter stay inside their ranges.

Period lengths cannot be seen from one cycle, so only the bench scenarios can show them. These cover the exact two-period total, the alternation of single periods for fractional products, and the clamping of low codes. The bench scenarios also show that a write made in the middle of a period changes the next period and not the current one.

// File: rtl/modclk_pkg.sv
// Shared constants for the modulator clock divider.
// Assumes: the stage-one code width is at least the stage-two code width.
package modclk_pkg;
    localparam logic SEL_STAGE1   = 1'b0;  // cfg_sel value addressing stage one
    localparam logic SEL_STAGE2   = 1'b1;  // cfg_sel value addressing stage two
    localparam int   MIN_CODE1    = 2;     // smallest usable stage-one code
    localparam int   QUARTER_STEP = 4;     // quarter-edge units added per core cycle
endpackage

// File: rtl/modclk_shadow.sv
// Holds the shadow and working copies of both divider codes.
// Writes always land in the shadow copies. On a load request the working
// copies take the shadow values, and the stage-one code is clamped to its
// usable minimum on the way. Assumes a load request is a single-cycle pulse.
module modclk_shadow
    import modclk_pkg::*;
#(
    parameter int P_W       = 6,
    parameter int S_W       = 4,
    parameter int RST_CODE1 = 28,
    parameter int RST_CODE2 = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic           cfg_sel,
    input  logic [P_W-1:0] cfg_data,
    input  logic           load,
    output logic [P_W:0]   q_len,
    output logic [S_W-1:0] r_act
);
    logic [P_W-1:0] e_sh, e_act;
    logic [S_W-1:0] r_sh;

    // Capture register writes into the shadow copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_sh <= P_W'(RST_CODE1);
            r_sh <= S_W'(RST_CODE2);
        end else if (cfg_we) begin
            if (cfg_sel == SEL_STAGE1) e_sh <= cfg_data;
            else                       r_sh <= cfg_data[S_W-1:0];
        end
    end

    // Transfer the shadow copies to the working copies at a load point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_act <= P_W'(RST_CODE1);
            r_act <= S_W'(RST_CODE2);
        end else if (load) begin
            e_act <= (e_sh < P_W'(MIN_CODE1)) ? P_W'(MIN_CODE1) : e_sh;
            r_act <= r_sh;
        end
    end

    // Stage-one half-period length, in quarter-cycle units.
    always_comb q_len = {1'b0, e_act} + (P_W+1)'(2);

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(e_act) && $stable(r_act)));
endmodule

// File: rtl/modclk_phase.sv
// Stage one: a fractional edge generator. Each core cycle it adds four
// quarter units to an accumulator. When the total reaches q_len it emits one
// edge pulse and keeps the remainder, so the edges average q_len/4 cycles
// apart. Assumes q_len >= 4, so at most one edge falls in each cycle.
module modclk_phase
    import modclk_pkg::*;
#(
    parameter int P_W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [P_W:0] q_len,
    output logic         edge_o
);
    localparam int AW = P_W + 2;

    logic [AW-1:0] acc_q, sum;

    // Add this cycle's step and decide whether an edge is due.
    always_comb begin
        sum    = acc_q + AW'(QUARTER_STEP);
        edge_o = run && (sum >= {1'b0, q_len});
    end

    // Advance the accumulator; clear it on restart or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) acc_q <= '0;
        else if (edge_o)                acc_q <= sum - {1'b0, q_len};
        else                            acc_q <= sum;
    end

    // R2
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (acc_q < {1'b0, q_len}));
endmodule

// File: rtl/modclk_count.sv
// Stage two: counts the stage-one edges modulo 2*(r+1) and drives the
// output. The output is high during the first r+1 edge intervals of each
// period. The wrap pulse marks the rising edge that starts a new period.
// Assumes edge_i is only asserted while running.
module modclk_count #(
    parameter int S_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           start,
    input  logic           edge_i,
    input  logic [S_W-1:0] r_act,
    output logic           wrap_o,
    output logic           mod_clk
);
    localparam int CW = S_W + 1;

    logic [CW-1:0] cnt_q, cnt_n, lim, half;

    // Derive the last count of the period and the next count.
    always_comb begin
        lim    = {r_act, 1'b1};
        half   = {1'b0, r_act};
        wrap_o = edge_i && (cnt_q == lim);
        cnt_n  = (cnt_q == lim) ? '0 : cnt_q + CW'(1);
    end

    // Step the edge counter and the registered output.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q   <= '0;
            mod_clk <= 1'b0;
        end else if (start) begin
            cnt_q   <= '0;
            mod_clk <= 1'b1;
        end else if (edge_i) begin
            cnt_q   <= cnt_n;
            mod_clk <= (cnt_n <= half);
        end
    end

    // R5
    dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mod_clk);
    // R6
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> mod_clk);
    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);
endmodule

// File: rtl/modclk_gen.sv
// Top level of the two-stage modulator clock divider. It tracks the run
// state, asks for a load at start and at each period wrap, and connects the
// register store, the fractional edge generator and the output counter.
// Assumes P_W >= S_W; cfg_data is P_W bits wide.
module modclk_gen #(
    parameter int P_W       = 6,
    parameter int S_W       = 4,
    parameter int RST_CODE1 = 28,
    parameter int RST_CODE2 = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           cfg_we,
    input  logic           cfg_sel,
    input  logic [P_W-1:0] cfg_data,
    output logic           mod_clk
);
    logic           running_q, start, run, edge_s, wrap_s, load;
    logic [P_W:0]   q_len;
    logic [S_W-1:0] r_act;

    // Remember whether the divider was enabled in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) running_q <= 1'b0;
        else        running_q <= en;
    end

    // Start pulse, steady-run flag and load request.
    always_comb begin
        start = en && !running_q;
        run   = en && running_q;
        load  = start || wrap_s;
    end

    modclk_shadow #(.P_W(P_W), .S_W(S_W), .RST_CODE1(RST_CODE1), .RST_CODE2(RST_CODE2)) u_shadow (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .load(load), .q_len(q_len), .r_act(r_act)
    );

    modclk_phase #(.P_W(P_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(start),
        .q_len(q_len), .edge_o(edge_s)
    );

    modclk_count #(.S_W(S_W)) u_count (
        .clk(clk), .rst_n(rst_n), .en(en), .start(start), .edge_i(edge_s),
        .r_act(r_act), .wrap_o(wrap_s), .mod_clk(mod_clk)
    );
endmodule

// File: tb/sim_modclk_gen.sv
// Sweeps stage-one codes 0..20 against stage-two codes 0..3 and checks
// output periods arithmetically; also tests reset, disable and mid-run writes.
module sim_modclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [5:0] cfg_data = '0;
    logic       mod_clk;

    int cyc = 0;
    int rise_cnt = 0;
    int last_rise = 0;
    logic prev_s = 1'b0;
    int checks = 0;
    int fails = 0;

    modclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .mod_clk(mod_clk)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Record rising edges of the output, sampled mid-cycle.
    always @(negedge clk) begin
        if (mod_clk && !prev_s) begin
            rise_cnt  = rise_cnt + 1;
            last_rise = cyc;
        end
        prev_s = mod_clk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic get_rise(output int t);
        int n;
        n = rise_cnt;
        do @(posedge clk); while (rise_cnt == n);
        t = last_rise;
    endtask

    task automatic wr(input logic sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = 6'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Program both codes, start, and measure two periods.
    task automatic run_cfg(input int e, input int r, input string req);
        int ee, total, t0, t1, t2, en_cyc;
        @(negedge clk); en = 1'b0;
        repeat (2) @(negedge clk);
        wr(1'b0, e);
        wr(1'b1, r);
        @(negedge clk);
        en = 1'b1; en_cyc = cyc;
        ee = (e < 2) ? 2 : e;
        total = (ee + 2) * (r + 1);
        get_rise(t0);
        // R6 first rise one cycle after enable
        check(t0 == en_cyc + 1, "R6", t0 - en_cyc, 1);
        get_rise(t1);
        get_rise(t2);
        // R2 two-period total / R4 clamped code
        check(t2 - t0 == total, req, t2 - t0, total);
        // R3 single period is floor or ceil of half the total
        check((t1 - t0 == total / 2) || (t1 - t0 == (total + 1) / 2), "R3", t1 - t0, total / 2);
    endtask

    initial begin
        int t0, t1, t2, t3, t4;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 output low after reset
        check(mod_clk == 1'b0, "R1", int'(mod_clk), 0);

        // R1 defaults: codes 0x1C and 0x00 give 30 cycles over two periods
        @(negedge clk); en = 1'b1;
        get_rise(t0); get_rise(t1); get_rise(t2);
        check(t2 - t0 == 30, "R1", t2 - t0, 30);
        check(t1 - t0 == 15, "R1", t1 - t0, 15);

        for (int e = 0; e <= 20; e++)
            for (int r = 0; r < 4; r++)
                run_cfg(e, r, (e < 2) ? "R4" : "R2");

        // R7 mid-period write takes effect at the next rising edge
        @(negedge clk); en = 1'b0;
        wr(1'b0, 10);
        wr(1'b1, 0);
        @(negedge clk); en = 1'b1;
        get_rise(t0); get_rise(t1);
        check(t1 - t0 == 6, "R7", t1 - t0, 6);
        wr(1'b0, 2);
        wr(1'b1, 1);
        get_rise(t2); get_rise(t3); get_rise(t4);
        check(t2 - t1 == 6, "R7", t2 - t1, 6);
        check(t3 - t2 == 4, "R7", t3 - t2, 4);
        check(t4 - t3 == 4, "R7", t4 - t3, 4);

        // R5 disable forces the output low and keeps it low
        @(negedge clk); en = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check(mod_clk == 1'b0, "R5", int'(mod_clk), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #1500000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule